// File: doc/BRIEF.md
# Processor Status Register with Logic and Shift Unit

This block holds an 8-bit processor status register and, next to it, a single-cycle datapath for the logic-class instructions of a small accumulator machine: bitwise OR, bitwise AND, a bit-test that affects only flags, shift left, and rotate left through carry. It also carries out the flag-only instructions that set or clear carry and load the register from a popped stack byte. It always presents the status register in the form used when it is pushed to a stack.

The sequencer of the surrounding processor presents one operation per clock with `op_valid` high. It supplies the accumulator value and the operand value. For a shift or rotate of the accumulator, the sequencer routes the accumulator onto the operand input. One clock later the block shows the registered result, a write enable that tells the sequencer to store that result, and the updated status. Add, subtract, decimal arithmetic and interrupt sequencing are handled elsewhere.

Status layout, bit 7 down to 0: negative N, overflow V, constant one, break B, decimal D, interrupt disable I, zero Z, carry C.

Top module: `psr_logic_unit`

## Requirements
- R1: After synchronous reset, `status_o` is 0x20 (0x24 when parameter `RESET_IDIS` is 1) and `result_we_o` is 0.
- R2: op_code 0 (OR) and op_code 1 (AND) produce `acc_in | opnd_in` or `acc_in & opnd_in` on `result_o` with `result_we_o` = 1. They update only Z and N, leaving C, I, D, B and V unchanged.
- R3: For every operation that writes a result, Z is set exactly when the 8-bit result is 0, and N equals result bit 7.
- R4: op_code 3 (shift left) produces `opnd_in << 1` with bit 0 cleared and `result_we_o` = 1. The bit shifted out of bit 7 becomes C.
- R5: op_code 4 (rotate left) produces `{opnd_in[6:0], C_old}` with `result_we_o` = 1. C takes `opnd_in[7]`.
- R6: op_code 2 (bit-test) sets Z when `acc_in & opnd_in` is 0, copies `opnd_in[7]` into N and `opnd_in[6]` into V, and leaves C, I, D and B unchanged. `result_we_o` is 0.
- R7: op_code 5 clears C and op_code 6 sets C. No other status bit changes, and `result_we_o` is 0.
- R8: op_code 7 (status pull) loads `opnd_in` into the status register with bit 5 forced to one. `result_we_o` is 0.
- R9: Status bit 5 always reads one. `push_byte_o` equals `status_o` with bit 4 (break) forced to one.
- R10: A cycle with `op_valid` low leaves the status unchanged and drives `result_we_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select (see requirements) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand value, or pulled byte for op_code 7 |
| result_o | output | 8 | Registered result |
| result_we_o | output | 1 | Result must be written back |
| status_o | output | 8 | Status register |
| push_byte_o | output | 8 | Status in stack-push form |

## Verification
Random accumulator, operand and operation codes run through a reference model with a carried status. Because the carry is carried along, rotate left is tested with both carry-in values. Because flag history is kept, the tests show whether an operation disturbs flags it must leave alone. Directed cases cover the following:
- zero results from OR and AND;
- a shift that empties the byte while setting carry;
- a bit-test where the AND is zero but the operand's top bits are set, which separates the Z source from the N and V sources;
- pulls of 0x00, 0xFF and a byte with bit 5 clear;
- idle cycles placed after flag changes.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    OP_OR   = 3'd0,
    OP_AND  = 3'd1,
    OP_BIT  = 3'd2,
    OP_SHL  = 3'd3,
    OP_ROL  = 3'd4,
    OP_CLRC = 3'd5,
    OP_SETC = 3'd6,
    OP_PULL = 3'd7
  } psr_op_e;

  localparam int B_C   = 0;
  localparam int B_Z   = 1;
  localparam int B_I   = 2;
  localparam int B_D   = 3;
  localparam int B_B   = 4;
  localparam int B_ONE = 5;
  localparam int B_V   = 6;
  localparam int B_N   = 7;
endpackage

// File: rtl/psr_logic_core.sv
module psr_logic_core
  import psr_pkg::*;
(
  input  psr_op_e        op,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  opnd,
  input  logic           c_in,
  output logic [DW-1:0]  res,
  output logic           res_wr,
  output logic           upd_zn,
  output logic           upd_c,
  output logic           bit_test,
  output logic           c_out,
  output logic           z_out
);
  always_comb begin
    res      = '0;
    res_wr   = 1'b0;
    upd_zn   = 1'b0;
    upd_c    = 1'b0;
    bit_test = 1'b0;
    c_out    = c_in;
    case (op)
      OP_OR: begin
        res    = acc | opnd;
        res_wr = 1'b1;
        upd_zn = 1'b1;
      end
      OP_AND: begin
        res    = acc & opnd;
        res_wr = 1'b1;
        upd_zn = 1'b1;
      end
      OP_BIT: begin
        res      = acc & opnd;
        bit_test = 1'b1;
      end
      OP_SHL: begin
        {c_out, res} = {opnd, 1'b0};
        res_wr = 1'b1;
        upd_zn = 1'b1;
        upd_c  = 1'b1;
      end
      OP_ROL: begin
        {c_out, res} = {opnd, c_in};
        res_wr = 1'b1;
        upd_zn = 1'b1;
        upd_c  = 1'b1;
      end
      default: begin
        res = '0;
      end
    endcase
    z_out = (res == '0);
  end
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
#(
  parameter bit RESET_IDIS = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  psr_op_e        op,
  input  logic [DW-1:0]  opnd,
  input  logic [DW-1:0]  res,
  input  logic           upd_zn,
  input  logic           upd_c,
  input  logic           bit_test,
  input  logic           c_new,
  input  logic           z_new,
  output logic [DW-1:0]  sr_q,
  output logic [DW-1:0]  push_byte
);
  localparam logic [DW-1:0] RST_VAL =
    (DW'(1) << B_ONE) | (RESET_IDIS ? (DW'(1) << B_I) : '0);

  logic [DW-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (valid) begin
      case (op)
        OP_CLRC: sr_d[B_C] = 1'b0;
        OP_SETC: sr_d[B_C] = 1'b1;
        OP_PULL: sr_d      = opnd;
        default: begin
          if (upd_zn) begin
            sr_d[B_Z] = z_new;
            sr_d[B_N] = res[DW-1];
          end
          if (bit_test) begin
            sr_d[B_Z] = z_new;
            sr_d[B_N] = opnd[B_N];
            sr_d[B_V] = opnd[B_V];
          end
          if (upd_c) sr_d[B_C] = c_new;
        end
      endcase
    end
    sr_d[B_ONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= RST_VAL;
    else     sr_q <= sr_d;
  end

  always_comb begin
    push_byte      = sr_q;
    push_byte[B_B] = 1'b1;
  end

  p_const_one_r9: assert property (@(posedge clk) disable iff (rst)
    sr_q[B_ONE] == 1'b1);

  p_push_break_r9: assert property (@(posedge clk) disable iff (rst)
    push_byte[B_B] && (push_byte[3:0] == sr_q[3:0]) && (push_byte[7:5] == sr_q[7:5]));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(sr_q));

  p_shift_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_SHL) |=> sr_q[B_C] == $past(opnd[DW-1]));

  p_clear_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_CLRC) |=> !sr_q[B_C] && sr_q[7:1] == $past(sr_q[7:1]));

  p_bit_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_BIT) |=> sr_q[7:6] == $past(opnd[7:6]) && sr_q[B_C] == $past(sr_q[B_C]));
endmodule

// File: rtl/psr_logic_unit.sv
module psr_logic_unit
  import psr_pkg::*;
#(
  parameter bit RESET_IDIS = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [7:0]   acc_in,
  input  logic [7:0]   opnd_in,
  output logic [7:0]   result_o,
  output logic         result_we_o,
  output logic [7:0]   status_o,
  output logic [7:0]   push_byte_o
);
  psr_op_e       op;
  logic [DW-1:0] core_res;
  logic          core_wr, core_zn, core_c, core_bit, core_cout, core_z;

  assign op = psr_op_e'(op_code);

  psr_logic_core u_core (
    .op       (op),
    .acc      (acc_in),
    .opnd     (opnd_in),
    .c_in     (status_o[B_C]),
    .res      (core_res),
    .res_wr   (core_wr),
    .upd_zn   (core_zn),
    .upd_c    (core_c),
    .bit_test (core_bit),
    .c_out    (core_cout),
    .z_out    (core_z)
  );

  psr_status_reg #(.RESET_IDIS(RESET_IDIS)) u_sr (
    .clk       (clk),
    .rst       (rst),
    .valid     (op_valid),
    .op        (op),
    .opnd      (opnd_in),
    .res       (core_res),
    .upd_zn    (core_zn),
    .upd_c     (core_c),
    .bit_test  (core_bit),
    .c_new     (core_cout),
    .z_new     (core_z),
    .sr_q      (status_o),
    .push_byte (push_byte_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o    <= '0;
      result_we_o <= 1'b0;
    end else begin
      result_we_o <= op_valid && core_wr;
      if (op_valid && core_wr) result_o <= core_res;
    end
  end

  p_we_source_r2: assert property (@(posedge clk) disable iff (rst)
    result_we_o |-> $past(op_valid) &&
      ($past(op_code) == 3'd0 || $past(op_code) == 3'd1 ||
       $past(op_code) == 3'd3 || $past(op_code) == 3'd4));

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (rst)
    result_we_o |-> (status_o[B_Z] == (result_o == 8'h00)) && (status_o[B_N] == result_o[7]));
endmodule

// File: tb/psr_logic_unit_tb.sv
module psr_logic_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [2:0] op_code;
  logic [7:0] acc_in, opnd_in;
  logic [7:0] result_o, status_o, push_byte_o;
  logic       result_we_o;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;
  logic [7:0] sr_m;

  always #10 clk = ~clk;

  psr_logic_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .result_o(result_o),
    .result_we_o(result_we_o), .status_o(status_o), .push_byte_o(push_byte_o)
  );

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R6";
      3'd3:       return "R4";
      3'd4:       return "R5";
      3'd5, 3'd6: return "R7";
      default:    return "R8";
    endcase
  endfunction

  // returns {we, result, status}
  function automatic logic [16:0] model(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] s);
    logic [7:0] r = 8'h00;
    logic [7:0] ns = s;
    logic we = 1'b0;
    case (op)
      3'd0: begin r = a | b; we = 1; end
      3'd1: begin r = a & b; we = 1; end
      3'd2: begin
        ns[1] = ((a & b) == 8'h00);
        ns[7] = b[7];
        ns[6] = b[6];
      end
      3'd3: begin r = {b[6:0], 1'b0}; we = 1; ns[0] = b[7]; end
      3'd4: begin r = {b[6:0], s[0]}; we = 1; ns[0] = b[7]; end
      3'd5: ns[0] = 1'b0;
      3'd6: ns[0] = 1'b1;
      default: ns = b;
    endcase
    if (we) begin
      ns[1] = (r == 8'h00);
      ns[7] = r[7];
    end
    ns[5] = 1'b1;
    return {we, r, ns};
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [16:0] e;
    logic [7:0]  old_res;
    string t;
    t = tag_of(op);
    old_res = result_o;
    e = model(op, a, b, sr_m);
    op_valid = 1'b1; op_code = op; acc_in = a; opnd_in = b;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    chk(t, "write enable", {7'd0, result_we_o}, {7'd0, e[16]});
    if (e[16]) chk(t, "result", result_o, e[15:8]);
    else       chk(t, "result held", result_o, old_res);
    chk(e[16] ? "R3" : t, "status", status_o, e[7:0]);
    chk("R9", "push byte", push_byte_o, e[7:0] | 8'h10);
    sr_m = e[7:0];
  endtask

  task automatic idle_check();
    @(posedge clk); @(negedge clk);
    chk("R10", "idle status", status_o, sr_m);
    chk("R10", "idle write enable", {7'd0, result_we_o}, 8'h00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; op_valid = 1'b0; op_code = 3'd0; acc_in = 8'h00; opnd_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    sr_m = 8'h20;
    chk("R1", "reset status", status_o, 8'h20);
    chk("R1", "reset write enable", {7'd0, result_we_o}, 8'h00);
    chk("R9", "reset push byte", push_byte_o, 8'h30);

    // directed corners
    apply(3'd0, 8'h00, 8'h00);   // R2 OR zero
    apply(3'd1, 8'hF0, 8'h8F);   // R2 AND negative
    apply(3'd6, 8'h00, 8'h00);   // R7 set carry
    apply(3'd1, 8'h0F, 8'hF0);   // R2 carry kept, zero
    apply(3'd3, 8'h00, 8'h80);   // R4 empties byte, carry out
    apply(3'd4, 8'h00, 8'h00);   // R5 carry in 1 -> 0x01
    apply(3'd4, 8'h00, 8'h40);   // R5 carry in 0 -> 0x80
    apply(3'd2, 8'h3F, 8'hC0);   // R6 zero AND, N V set
    idle_check();
    apply(3'd2, 8'h01, 8'h01);   // R6 nonzero AND, N V cleared
    apply(3'd5, 8'h00, 8'h00);   // R7 clear carry
    apply(3'd7, 8'h00, 8'h00);   // R8 pull zero
    apply(3'd7, 8'h00, 8'hFF);   // R8 pull all ones
    idle_check();
    apply(3'd7, 8'h00, 8'hCF);   // R8 bit 5 forced
    apply(3'd7, 8'h00, 8'h0C);   // R8 restore I D

    for (int i = 0; i < 400; i++) begin
      apply(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom));
      if (($urandom % 8) == 0) idle_check();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule